// File: doc/BRIEF.md
# Next Program Counter Unit

This block works out the address of the next instruction once per clock. It takes the address of the current instruction, two register operands, a 16-bit branch displacement, an absolute jump target and a 4-bit control-flow code. It selects the sequential address, a relative branch target, the absolute target or the first operand, and registers the result. It also flags whether the flow of the program was redirected.

For the call type it also produces the return address, a write enable for it and the index of the register that receives it, which is fixed at 31. The registered outputs sit at the boundary between the execute stage and the fetch stage. Fetching, delay slots and branch prediction are handled outside the block.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge.
- R2: Every output reflects the inputs that were present at the previous rising edge, so the latency is exactly one cycle.
- R3: Code 0 (sequential) yields `nxt_pc` = `cur_pc` + 4 with `redirect` low. Codes 10 to 15 are unused and behave the same way.
- R4: Code 1 is taken when `opnd_a` equals `opnd_b`. Code 2 is taken when they differ.
- R5: Codes 3, 4, 5 and 6 compare `opnd_b` with zero as a signed number. Code 3 is taken when it is below zero, code 4 when it is above zero, code 5 when it is at or below zero, and code 6 when it is at or above zero.
- R6: A taken relative transfer gives `nxt_pc` = `cur_pc` + 4 + 4·sext(`br_off`), computed modulo 2^32, with `redirect` high.
- R7: Code 7 (unconditional relative branch) is always taken and uses the R6 target.
- R8: Code 8 (call) gives `nxt_pc` = `jmp_tgt`, `redirect` high, `link_val` = `cur_pc` + 4, `link_we` high and `link_dst` = 31.
- R9: Code 9 (register jump) gives `nxt_pc` = `opnd_a` with `redirect` high.
- R10: For every code other than 8, `link_we` is low and both `link_val` and `link_dst` are zero.
- R11: A conditional code (1 to 6) whose condition fails gives `nxt_pc` = `cur_pc` + 4 with `redirect` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | 32 | Address of the current instruction |
| opnd_a | input | 32 | First register operand; equality operand and jump register |
| opnd_b | input | 32 | Second register operand; operand compared with zero |
| br_off | input | 16 | Signed word displacement for relative branches |
| jmp_tgt | input | 32 | Absolute target for the call type |
| cf_kind | input | 4 | Control-flow code |
| nxt_pc | output | 32 | Registered next instruction address |
| redirect | output | 1 | High when the next address is not the sequential one |
| link_val | output | 32 | Return address for the call type |
| link_we | output | 1 | Return-address write enable |
| link_dst | output | 5 | Destination register index for the return address |

## Verification
Every result (`nxt_pc`, `redirect` and the three link outputs) is due at the first rising edge after its inputs are applied, and none is due earlier or later. The bench applies each stimulus on a falling edge and compares all five outputs on the next falling edge, half a cycle after the one registering edge. Each comparison uses a reference computed from the sampled stimulus. The sweep covers all sixteen codes, operand pairs at the signed boundaries, and displacements that reach both extremes and wrap the address.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN  = 32;
    localparam int RIDXW = 5;

    typedef enum logic [3:0] {
        CF_SEQ  = 4'd0,
        CF_BEQ  = 4'd1,
        CF_BNE  = 4'd2,
        CF_BLTZ = 4'd3,
        CF_BGTZ = 4'd4,
        CF_BLEZ = 4'd5,
        CF_BGEZ = 4'd6,
        CF_BRA  = 4'd7,
        CF_CALL = 4'd8,
        CF_JREG = 4'd9
    } cf_kind_e;

    typedef struct packed {
        logic [XLEN-1:0]  pc;
        logic             redirect;
        logic [XLEN-1:0]  lval;
        logic             lwe;
        logic [RIDXW-1:0] ldst;
    } npc_res_t;

    // Relative transfers share one target formula.
    function automatic logic is_relative(cf_kind_e k);
        return (k == CF_BEQ) || (k == CF_BNE) || (k == CF_BLTZ) ||
               (k == CF_BGTZ) || (k == CF_BLEZ) || (k == CF_BGEZ) ||
               (k == CF_BRA);
    endfunction

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  cf_kind_e       kind,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           take
);
    logic eq, neg, zero;

    assign eq   = (a == b);
    assign neg  = b[W-1];
    assign zero = (b == '0);

    always_comb begin
        unique case (kind)
            CF_BEQ:  take = eq;
            CF_BNE:  take = !eq;
            CF_BLTZ: take = neg;
            CF_BGTZ: take = !neg && !zero;
            CF_BLEZ: take = neg || zero;
            CF_BGEZ: take = !neg;
            CF_BRA:  take = 1'b1;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
    import npc_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int OFFW = 16,
    parameter int STEP = 4
) (
    input  logic [W-1:0]    pc,
    input  logic [OFFW-1:0] off,
    output logic [W-1:0]    seq_pc,
    output logic [W-1:0]    rel_pc
);
    localparam int SH = $clog2(STEP);

    logic [W-1:0] off_ext;

    assign off_ext = {{(W-OFFW){off[OFFW-1]}}, off};
    assign seq_pc  = pc + W'(STEP);
    assign rel_pc  = seq_pc + (off_ext << SH);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int OFFW   = 16,
    parameter int STEP   = 4,
    parameter int RA_IDX = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    input  logic [OFFW-1:0]   br_off,
    input  logic [XLEN-1:0]   jmp_tgt,
    input  logic [3:0]        cf_kind,
    output logic [XLEN-1:0]   nxt_pc,
    output logic              redirect,
    output logic [XLEN-1:0]   link_val,
    output logic              link_we,
    output logic [RIDXW-1:0]  link_dst
);
    cf_kind_e        kind;
    logic            take;
    logic [XLEN-1:0] seq_pc, rel_pc;
    npc_res_t        nxt_d, res_q;

    assign kind = cf_kind_e'(cf_kind);

    npc_cond_eval #(.W(XLEN)) u_cond (
        .kind (kind),
        .a    (opnd_a),
        .b    (opnd_b),
        .take (take)
    );

    npc_target_gen #(.W(XLEN), .OFFW(OFFW), .STEP(STEP)) u_tgt (
        .pc     (cur_pc),
        .off    (br_off),
        .seq_pc (seq_pc),
        .rel_pc (rel_pc)
    );

    always_comb begin
        nxt_d          = '0;
        nxt_d.pc       = seq_pc;
        if (is_relative(kind) && take) begin
            nxt_d.pc       = rel_pc;
            nxt_d.redirect = 1'b1;
        end else if (kind == CF_CALL) begin
            nxt_d.pc       = jmp_tgt;
            nxt_d.redirect = 1'b1;
            nxt_d.lval     = seq_pc;
            nxt_d.lwe      = 1'b1;
            nxt_d.ldst     = RIDXW'(RA_IDX);
        end else if (kind == CF_JREG) begin
            nxt_d.pc       = opnd_a;
            nxt_d.redirect = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= nxt_d;
    end

    assign nxt_pc   = res_q.pc;
    assign redirect = res_q.redirect;
    assign link_val = res_q.lval;
    assign link_we  = res_q.lwe;
    assign link_dst = res_q.ldst;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
    import npc_pkg::*;
#(
    parameter int OFFW   = 16,
    parameter int STEP   = 4,
    parameter int RA_IDX = 31
) (
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   cur_pc,
    input logic [XLEN-1:0]   opnd_a,
    input logic [XLEN-1:0]   opnd_b,
    input logic [OFFW-1:0]   br_off,
    input logic [XLEN-1:0]   jmp_tgt,
    input logic [3:0]        cf_kind,
    input logic [XLEN-1:0]   nxt_pc,
    input logic              redirect,
    input logic [XLEN-1:0]   link_val,
    input logic              link_we,
    input logic [RIDXW-1:0]  link_dst
);
    // High once the previous edge was a working (non-reset) edge.
    logic live;
    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    p_seq_r3: assert property (@(posedge clk) disable iff (rst)
        (live && $past(cf_kind) == 4'd0) |->
            (nxt_pc == $past(cur_pc) + XLEN'(STEP) && !redirect));

    p_call_r8: assert property (@(posedge clk) disable iff (rst)
        (live && $past(cf_kind) == 4'd8) |->
            (link_we && redirect && nxt_pc == $past(jmp_tgt) &&
             link_val == $past(cur_pc) + XLEN'(STEP) &&
             link_dst == RIDXW'(RA_IDX)));

    p_jreg_r9: assert property (@(posedge clk) disable iff (rst)
        (live && $past(cf_kind) == 4'd9) |->
            (redirect && nxt_pc == $past(opnd_a)));

    p_link_only_call_r10: assert property (@(posedge clk) disable iff (rst)
        (live && link_we) |-> ($past(cf_kind) == 4'd8));

    p_fallthru_r11: assert property (@(posedge clk) disable iff (rst)
        (live && !redirect) |-> (nxt_pc == $past(cur_pc) + XLEN'(STEP)));

    p_beq_r4: assert property (@(posedge clk) disable iff (rst)
        (live && $past(cf_kind) == 4'd1 && $past(opnd_a) == $past(opnd_b))
            |-> redirect);

    p_bra_r7: assert property (@(posedge clk) disable iff (rst)
        (live && $past(cf_kind) == 4'd7) |-> redirect);
endmodule

bind npc_unit npc_unit_chk #(.OFFW(OFFW), .STEP(STEP), .RA_IDX(RA_IDX)) u_chk (.*);

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cur_pc, opnd_a, opnd_b, jmp_tgt;
    logic [15:0] br_off;
    logic [3:0]  cf_kind;
    logic [31:0] nxt_pc, link_val;
    logic        redirect, link_we;
    logic [4:0]  link_dst;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    npc_unit dut (
        .clk(clk), .rst(rst), .cur_pc(cur_pc), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .br_off(br_off), .jmp_tgt(jmp_tgt),
        .cf_kind(cf_kind), .nxt_pc(nxt_pc), .redirect(redirect),
        .link_val(link_val), .link_we(link_we), .link_dst(link_dst)
    );

    function automatic string tag_of(logic [3:0] k);
        if (k == 0 || k >= 10) return "R3";
        if (k <= 2)            return "R4/R6/R11";
        if (k <= 6)            return "R5/R6/R11";
        if (k == 7)            return "R7";
        if (k == 8)            return "R8";
        return "R9/R10";
    endfunction

    task automatic expect_out(string tag, logic [31:0] e_pc, logic e_rd,
                              logic [31:0] e_lv, logic e_we, logic [4:0] e_ld);
        checks++;
        if (nxt_pc !== e_pc || redirect !== e_rd || link_val !== e_lv ||
            link_we !== e_we || link_dst !== e_ld) begin
            fails++;
            $display("FAIL %s kind=%0d act pc=%h rd=%b lv=%h we=%b ld=%0d exp pc=%h rd=%b lv=%h we=%b ld=%0d",
                     tag, cf_kind, nxt_pc, redirect, link_val, link_we, link_dst,
                     e_pc, e_rd, e_lv, e_we, e_ld);
        end
    endtask

    // Drive on a falling edge, compare on the next one (R2).
    task automatic run_vec(logic [3:0] k, logic [31:0] pc, logic [31:0] a,
                           logic [31:0] b, logic [15:0] off, logic [31:0] tg);
        logic [31:0] seq, rel, e_pc;
        logic        tk, e_rd;
        cf_kind = k; cur_pc = pc; opnd_a = a; opnd_b = b;
        br_off = off; jmp_tgt = tg;
        seq = pc + 32'd4;
        rel = seq + 32'(4 * $signed({{16{off[15]}}, off}));
        case (k)
            4'd1: tk = (a == b);
            4'd2: tk = (a != b);
            4'd3: tk = ($signed(b) < 0);
            4'd4: tk = ($signed(b) > 0);
            4'd5: tk = ($signed(b) <= 0);
            4'd6: tk = ($signed(b) >= 0);
            4'd7: tk = 1'b1;
            default: tk = 1'b0;
        endcase
        e_pc = tk ? rel : seq;
        e_rd = tk;
        if (k == 4'd8) begin e_pc = tg; e_rd = 1'b1; end
        if (k == 4'd9) begin e_pc = a;  e_rd = 1'b1; end
        @(negedge clk);
        if (k == 4'd8) expect_out("R8 R2", e_pc, e_rd, seq, 1'b1, 5'd31);
        else           expect_out({tag_of(k), " R10 R2"}, e_pc, e_rd, 32'd0, 1'b0, 5'd0);
    endtask

    initial begin
        logic [31:0] ops [6];
        logic [15:0] offs [5];
        ops[0] = 32'h0;        ops[1] = 32'h1;        ops[2] = 32'hFFFF_FFFF;
        ops[3] = 32'h7FFF_FFFF; ops[4] = 32'h8000_0000; ops[5] = 32'h5;
        offs[0] = 16'h0; offs[1] = 16'h1; offs[2] = 16'hFFFF;
        offs[3] = 16'h7FFF; offs[4] = 16'h8000;
        rst = 1'b1; cf_kind = 4'd8; cur_pc = 32'h1234; opnd_a = 32'h55;
        opnd_b = 32'h0; br_off = 16'h1; jmp_tgt = 32'hABCD;
        @(negedge clk); @(negedge clk);
        expect_out("R1", 32'd0, 1'b0, 32'd0, 1'b0, 5'd0);
        rst = 1'b0;
        for (int k = 0; k < 16; k++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    for (int o = 0; o < 5; o++)
                        run_vec(4'(k), 32'hFFFF_FFF0 + 32'(o * 4) + 32'(i * 32'h1000_0000),
                                ops[i], ops[j], offs[o], 32'h0040_0000 + 32'(j * 4));
        // Reset in the middle of a run clears a pending call result (R1).
        cf_kind = 4'd8; rst = 1'b1;
        @(negedge clk);
        expect_out("R1", 32'd0, 1'b0, 32'd0, 1'b0, 5'd0);
        rst = 1'b0;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog act=running exp=finished");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule